// File: doc/BRIEF.md
# Expansion-Slot Link Adapter Host Interface

This block is the glue between an 8-bit expansion slot and a serial link adapter that serves an attached processor module. The host reaches the block through a 16-byte I/O window. The slot's base address selects the window: it sits at 0xC080 plus 0x10 times the slot number. That decode happens outside the block, so the block sees only the device select and the low four address bits.

Four offsets pass through to the adapter:

| Offset | Read | Write |
|--------|------|-------|
| 0 | received data byte | no effect |
| 1 | returns 0x00 | transmit data byte |
| 2 | input status | input status |
| 3 | output status | output status |

For offsets 2 and 3, bit 0 carries the data-ready flag and the transmit-ready flag. Writing zero to either status register clears its interrupt enable inside the adapter.

Two more offsets reach the processor module:

- Offset 8: a write sets the module reset level from data bit 0. A read returns the module error flag in bit 0.
- Offset 12: a write sets the analyse level from data bit 0.

Both control levels are held in latches. Each latch moves only on its own write, so the host can run the sequence "reset low, analyse high, reset high" safely.

A host access is one clock cycle with `host_sel` high. The adapter strobes, the register select and the read data are combinational within that cycle. The module control latches take the new value at the clock edge that ends the write.

Top module: `lapt_slot_if`

## Requirements
- R1: The adapter read strobe is high exactly in a cycle with `host_sel` high, `host_rnw` high and offset 0, 2 or 3. `adp_rs` always equals `host_addr[1:0]`.
- R2: The adapter write strobe is high exactly in a cycle with `host_sel` high, `host_rnw` low and offset 1, 2 or 3. `adp_wdata` carries `host_wdata`.
- R3: A read at offset 0, 2 or 3 returns `adp_rdata` on `host_rdata` in the same cycle.
- R4: A write at offset 8 sets `mod_reset` to data bit 0 from the next clock edge. A read at offset 8 returns 0x00 with `mod_error` in bit 0.
- R5: A write at offset 12 sets `mod_analyse` to data bit 0 from the next clock edge.
- R6: Each control latch changes only on a write to its own offset. The host sequence "write 0 to offset 8, write 1 to offset 12, write 1 to offset 8" leaves both latches high.
- R7: A read at offset 1, 4–7 or 9–15 returns 0x00. A write at offset 0, 4–7, 9–11 or 13–15 raises no strobe and leaves both latches unchanged.
- R8: `host_buf_oe` is high exactly when `host_sel` and `host_rnw` are both high.
- R9: An active-low `rst_n` returns `mod_reset` and `mod_analyse` to their idle level, which is 0 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Device select for the slot window |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 4 | Offset within the window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data toward the host |
| host_buf_oe | output | 1 | Host data buffer output enable |
| adp_rs | output | 2 | Adapter register select |
| adp_rd_stb | output | 1 | Adapter read strobe |
| adp_wr_stb | output | 1 | Adapter write strobe |
| adp_wdata | output | 8 | Data toward the adapter |
| adp_rdata | input | 8 | Data from the adapter |
| mod_reset | output | 1 | Latched module reset level |
| mod_analyse | output | 1 | Latched module analyse level |
| mod_error | input | 1 | Module error flag |

## Verification
The assertions assume the host holds `host_sel`, `host_rnw`, `host_addr` and `host_wdata` steady across each clock edge. They also assume `adp_rdata` and `mod_error` are settled before the clock edge. The stimulus meets this by changing every input only on the falling edge. Accesses last one cycle each and are separated by random idle cycles. Random offsets, directions, data bytes and error levels are mixed with the directed reset-then-analyse sequence and a mid-run reset.

// File: rtl/lapt_pkg.sv
package lapt_pkg;

   localparam int unsigned LAPT_DW  = 8;
   localparam int unsigned LAPT_AW  = 4;
   localparam int unsigned LAPT_RSW = 2;

   typedef enum logic [LAPT_AW-1:0] {
      OFF_RXD   = 4'd0,
      OFF_TXD   = 4'd1,
      OFF_ISTAT = 4'd2,
      OFF_OSTAT = 4'd3,
      OFF_RST   = 4'd8,
      OFF_ANA   = 4'd12
   } lapt_off_e;

   typedef struct packed {
      logic adp_rd;
      logic adp_wr;
      logic rst_rd;
      logic rst_wr;
      logic ana_wr;
   } lapt_dec_t;

endpackage

// File: rtl/lapt_decode.sv
module lapt_decode
   import lapt_pkg::*;
#(
   parameter int unsigned AW  = LAPT_AW,
   parameter int unsigned RSW = LAPT_RSW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sel,
   input  logic           rnw,
   input  logic [AW-1:0]  addr,
   output lapt_dec_t      dec,
   output logic [RSW-1:0] rs,
   output logic           buf_oe
);

   localparam logic [AW-1:0] RXD_O = AW'(OFF_RXD);
   localparam logic [AW-1:0] TXD_O = AW'(OFF_TXD);
   localparam logic [AW-1:0] IST_O = AW'(OFF_ISTAT);
   localparam logic [AW-1:0] OST_O = AW'(OFF_OSTAT);
   localparam logic [AW-1:0] RST_O = AW'(OFF_RST);
   localparam logic [AW-1:0] ANA_O = AW'(OFF_ANA);

   if (AW != 4) begin : g_bad_aw
      $error("lapt_decode: window needs exactly 4 address bits");
   end
   if (RSW > AW) begin : g_bad_rsw
      $error("lapt_decode: register select wider than address");
   end

   logic rd_cyc;
   logic wr_cyc;
   logic is_rxd, is_txd, is_stat, is_rst, is_ana;

   assign rd_cyc  = sel &  rnw;
   assign wr_cyc  = sel & ~rnw;
   assign is_rxd  = (addr == RXD_O);
   assign is_txd  = (addr == TXD_O);
   assign is_stat = (addr == IST_O) | (addr == OST_O);
   assign is_rst  = (addr == RST_O);
   assign is_ana  = (addr == ANA_O);

   always_comb begin
      dec        = '0;
      dec.adp_rd = rd_cyc & (is_rxd | is_stat);
      dec.adp_wr = wr_cyc & (is_txd | is_stat);
      dec.rst_rd = rd_cyc & is_rst;
      dec.rst_wr = wr_cyc & is_rst;
      dec.ana_wr = wr_cyc & is_ana;
   end

   assign rs     = addr[RSW-1:0];
   assign buf_oe = rd_cyc;

   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec.adp_rd && dec.adp_wr)); // R1
   AST_OE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      buf_oe |-> !(dec.adp_wr || dec.rst_wr || dec.ana_wr)); // R8
   AST_ONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec.rst_wr && dec.ana_wr)); // R6

endmodule

// File: rtl/lapt_ctrl_bit.sv
module lapt_ctrl_bit #(
   parameter logic IDLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= IDLE;
      else if (ld) q <= d;
   end

   AST_HOLD_NO_LD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q)); // R6
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(d))); // R4

endmodule

// File: rtl/lapt_rdmux.sv
module lapt_rdmux
   import lapt_pkg::*;
#(
   parameter int unsigned DW = LAPT_DW,
   parameter int unsigned AW = LAPT_AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          rnw,
   input  logic [AW-1:0] addr,
   input  lapt_dec_t     dec,
   input  logic [DW-1:0] adp_rdata,
   input  logic          err,
   output logic [DW-1:0] rdata
);

   if (DW < 2) begin : g_bad_dw
      $error("lapt_rdmux: data width must be at least 2");
   end

   localparam logic [DW-1:0] ZERO = '0;

   always_comb begin
      rdata = ZERO;
      if (dec.adp_rd)      rdata = adp_rdata;
      else if (dec.rst_rd) rdata = {{(DW-1){1'b0}}, err};
   end

   AST_ERR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rnw && addr == AW'(8)) |-> (rdata == {{(DW-1){1'b0}}, err})); // R4
   AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rnw && (addr == AW'(1) || addr[2])) |-> (rdata == ZERO)); // R7
   AST_ADP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rnw && addr[AW-1:2] == '0 && addr != AW'(1)) |-> (rdata == adp_rdata)); // R3

endmodule

// File: rtl/lapt_slot_if.sv
module lapt_slot_if
   import lapt_pkg::*;
#(
   parameter int unsigned DW       = LAPT_DW,
   parameter int unsigned AW       = LAPT_AW,
   parameter int unsigned RSW      = LAPT_RSW,
   parameter logic        RST_IDLE = 1'b0,
   parameter logic        ANA_IDLE = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           host_sel,
   input  logic           host_rnw,
   input  logic [AW-1:0]  host_addr,
   input  logic [DW-1:0]  host_wdata,
   output logic [DW-1:0]  host_rdata,
   output logic           host_buf_oe,
   output logic [RSW-1:0] adp_rs,
   output logic           adp_rd_stb,
   output logic           adp_wr_stb,
   output logic [DW-1:0]  adp_wdata,
   input  logic [DW-1:0]  adp_rdata,
   output logic           mod_reset,
   output logic           mod_analyse,
   input  logic           mod_error
);

   localparam int unsigned NCTL = 2;
   localparam logic [NCTL-1:0] IDLE_VEC = {ANA_IDLE, RST_IDLE};

   lapt_dec_t       dec;
   logic [NCTL-1:0] ctl_ld;
   logic [NCTL-1:0] ctl_q;

   lapt_decode #(.AW(AW), .RSW(RSW)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (host_sel),
      .rnw    (host_rnw),
      .addr   (host_addr),
      .dec    (dec),
      .rs     (adp_rs),
      .buf_oe (host_buf_oe)
   );

   assign ctl_ld = {dec.ana_wr, dec.rst_wr};

   for (genvar gi = 0; gi < NCTL; gi++) begin : g_ctl
      lapt_ctrl_bit #(.IDLE(IDLE_VEC[gi])) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (ctl_ld[gi]),
         .d     (host_wdata[0]),
         .q     (ctl_q[gi])
      );
   end

   lapt_rdmux #(.DW(DW), .AW(AW)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (host_sel),
      .rnw       (host_rnw),
      .addr      (host_addr),
      .dec       (dec),
      .adp_rdata (adp_rdata),
      .err       (mod_error),
      .rdata     (host_rdata)
   );

   assign adp_rd_stb  = dec.adp_rd;
   assign adp_wr_stb  = dec.adp_wr;
   assign adp_wdata   = host_wdata;
   assign mod_reset   = ctl_q[0];
   assign mod_analyse = ctl_q[1];

   AST_STB_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (adp_rd_stb || adp_wr_stb) |-> host_sel); // R2
   AST_RST_OWN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_sel && !host_rnw && host_addr == AW'(8)) |=> $stable(mod_reset)); // R6
   AST_ANA_OWN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_sel && !host_rnw && host_addr == AW'(12)) |=> $stable(mod_analyse)); // R5

endmodule

// File: tb/lapt_slot_if_bench.sv
module lapt_slot_if_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0;
   logic       host_rnw = 1'b1;
   logic [3:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_buf_oe;
   logic [1:0] adp_rs;
   logic       adp_rd_stb, adp_wr_stb;
   logic [7:0] adp_wdata;
   logic [7:0] adp_rdata = '0;
   logic       mod_reset, mod_analyse;
   logic       mod_error = 1'b0;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  exp_rst = 1'b0;
   bit  exp_ana = 1'b0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lapt_slot_if u_lapt_slot_if (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rnw(host_rnw),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_buf_oe(host_buf_oe), .adp_rs(adp_rs), .adp_rd_stb(adp_rd_stb),
      .adp_wr_stb(adp_wr_stb), .adp_wdata(adp_wdata), .adp_rdata(adp_rdata),
      .mod_reset(mod_reset), .mod_analyse(mod_analyse), .mod_error(mod_error)
   );

   function automatic bit f_rd_stb(bit s, bit r, logic [3:0] a);
      return s && r && (a == 0 || a == 2 || a == 3);
   endfunction

   function automatic bit f_wr_stb(bit s, bit r, logic [3:0] a);
      return s && !r && (a == 1 || a == 2 || a == 3);
   endfunction

   function automatic logic [7:0] f_rdata(bit s, bit r, logic [3:0] a, logic [7:0] adp, bit e);
      if (!(s && r)) return 8'h00;
      if (a == 0 || a == 2 || a == 3) return adp;
      if (a == 8) return {7'b0, e};
      return 8'h00;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // check combinational outputs for current inputs
   task automatic chk_comb();
      logic [7:0] er;
      er = f_rdata(host_sel, host_rnw, host_addr, adp_rdata, mod_error);
      chk(adp_rd_stb == f_rd_stb(host_sel, host_rnw, host_addr), "R1 rd_stb",
          int'(adp_rd_stb), int'(f_rd_stb(host_sel, host_rnw, host_addr)));
      chk(adp_rs == host_addr[1:0], "R1 rs", int'(adp_rs), int'(host_addr[1:0]));
      chk(adp_wr_stb == f_wr_stb(host_sel, host_rnw, host_addr), "R2 wr_stb",
          int'(adp_wr_stb), int'(f_wr_stb(host_sel, host_rnw, host_addr)));
      chk(adp_wdata == host_wdata, "R2 wdata", int'(adp_wdata), int'(host_wdata));
      chk(host_rdata == er, "R3/R4/R7 rdata", int'(host_rdata), int'(er));
      chk(host_buf_oe == (host_sel && host_rnw), "R8 buf_oe",
          int'(host_buf_oe), int'(host_sel && host_rnw));
   endtask

   task automatic chk_latch(string req);
      chk(mod_reset == exp_rst, {req, " mod_reset"}, int'(mod_reset), int'(exp_rst));
      chk(mod_analyse == exp_ana, {req, " mod_analyse"}, int'(mod_analyse), int'(exp_ana));
   endtask

   // one-cycle host access starting at a falling edge
   task automatic access(bit rnw, logic [3:0] a, logic [7:0] d, logic [7:0] adp, bit e);
      @(negedge clk);
      host_sel = 1'b1; host_rnw = rnw; host_addr = a; host_wdata = d;
      adp_rdata = adp; mod_error = e;
      #(CLK_PERIOD/4);
      chk_comb();
      @(posedge clk);
      if (!rnw && a == 8)  exp_rst = d[0];
      if (!rnw && a == 12) exp_ana = d[0];
      #1;
      chk_latch((!rnw && (a == 8 || a == 12)) ? "R4/R5/R6" : "R6/R7");
      @(negedge clk);
      host_sel = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(posedge clk);
      #1;
      chk_latch("R9 reset");
      @(negedge clk); rst_n = 1'b1;
      #1; chk_comb();                       // R8 idle: no strobes, no oe

      // R6 directed: reset low, analyse high, reset high
      access(1'b0, 4'd8, 8'h00, 8'h00, 1'b0);
      access(1'b0, 4'd12, 8'h01, 8'h00, 1'b0);
      chk(mod_reset == 1'b0, "R6 seq reset unchanged", int'(mod_reset), 0);
      access(1'b0, 4'd8, 8'hFF, 8'h00, 1'b0);
      chk(mod_analyse && mod_reset, "R6 seq both high",
          int'({mod_analyse, mod_reset}), 3);

      // R7 directed: writes to undefined offsets leave latches
      for (int a = 0; a < 16; a++)
         if (a == 0 || (a >= 4 && a != 8 && a != 12))
            access(1'b0, 4'(a), 8'h00, 8'h00, 1'b0);
      // R4 error read both levels, R3 adapter passthrough
      access(1'b1, 4'd8, 8'h00, 8'hA5, 1'b1);
      access(1'b1, 4'd8, 8'h00, 8'hA5, 1'b0);
      access(1'b1, 4'd0, 8'h00, 8'h3C, 1'b1);
      access(1'b1, 4'd2, 8'h00, 8'h01, 1'b0);
      access(1'b1, 4'd3, 8'h00, 8'hFE, 1'b0);
      access(1'b1, 4'd1, 8'h00, 8'hFF, 1'b1);
      access(1'b1, 4'd12, 8'h00, 8'hFF, 1'b1);
      // R5 analyse back low with bit 0 only
      access(1'b0, 4'd12, 8'hFE, 8'h00, 1'b0);

      // random mix
      for (int i = 0; i < 2000; i++) begin
         access(1'($urandom), 4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
         repeat ($urandom % 3) @(negedge clk);
      end

      // R9 mid-run reset
      access(1'b0, 4'd8, 8'h01, 8'h00, 1'b0);
      access(1'b0, 4'd12, 8'h01, 8'h00, 1'b0);
      @(negedge clk); rst_n = 1'b0;
      exp_rst = 1'b0; exp_ana = 1'b0;
      #1; chk_latch("R9 midrun");
      @(negedge clk); rst_n = 1'b1;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule